// File: doc/BRIEF.md
# Conversion Data-Ready Status Controller

This block drives the active-low ready line that tells a host when a converter's output data register holds a word it has not yet read. It also raises a read-inhibit flag for the stretch of time in which that register is being rewritten. The converter announces each coming output update with a request strobe. The block then waits a fixed blanking window and issues a one-cycle load strobe that commits the new word. It holds the inhibit flag until the converter signals that the update has ended.

A word tracker watches the serial read port. It sees an active-low chip select and a one-cycle strobe for each serial clock edge, already synchronized to the system clock. When every bit of a word has been shifted out, the tracker marks the word as consumed. If chip select is tied low, words are framed purely by counting bits. In calibration mode the ready line instead reports calibration progress: it is high while a calibration runs and low once it completes. A low standby input freezes every register, so the block resumes exactly where it stopped.

Top module: `drdy_status_ctrl`

## Requirements
- R1: After reset `rdy_n` is 1, `rd_inhibit` is 0 and `upd_load` is 0. In conversion mode `rdy_n` stays 1 until the first update ends.
- R2: In conversion mode, an accepted `upd_req` sets `rdy_n` and `rd_inhibit` to 1 one cycle later, whether or not the current word was read. `upd_req` is accepted only when no update is pending.
- R3: `upd_load` is high for exactly one cycle. That cycle begins BLANK_CYC clock edges after the edge that samples the accepted `upd_req`, and `rd_inhibit` is high throughout it.
- R4: `upd_end` sampled after the load strobe clears `rd_inhibit` on the next cycle and, in conversion mode, drives `rdy_n` to 0. `upd_end` at any other time has no effect.
- R5: WORD_BITS `sck_edge` strobes taken while `cs_n` is 0 and `rd_inhibit` is 0 make up a full read. In conversion mode, `rdy_n` is 1 in the cycle after the last of these strobes.
- R6: `cs_n` going to 1 before a word is complete discards the partial count, and `rdy_n` does not change.
- R7: With `cs_n` held at 0, successive groups of WORD_BITS strobes each count as a full read.
- R8: An `sck_edge` strobe taken while `rd_inhibit` is 1 is not counted and discards any partial count.
- R9: In calibration mode (`cal_mode`=1), `cal_start` sets `rdy_n` to 1 and a following `cal_done` sets it to 0. Reads and update events leave `rdy_n` unchanged. A `cal_done` with no calibration running is ignored.
- R10: A calibration started while an update is pending keeps `rdy_n` at 1 past `upd_end`, until `cal_done`.
- R11: In conversion mode `cal_start` and `cal_done` have no effect on `rdy_n`.
- R12: While `stby_n` is 0, all strobes are ignored, all state is held, and `upd_load` is 0. A blanking window that was interrupted resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Low freezes the block with its state kept |
| cal_mode | input | 1 | 1 selects calibration mode, 0 selects conversion mode |
| upd_req | input | 1 | Strobe announcing a coming output update |
| upd_end | input | 1 | Strobe marking the end of the output update |
| cal_start | input | 1 | Calibration start strobe |
| cal_done | input | 1 | Calibration complete strobe |
| cs_n | input | 1 | Active-low chip select of the serial port |
| sck_edge | input | 1 | One-cycle strobe per serial bit shifted out |
| rdy_n | output | 1 | Active-low data-ready / calibration status |
| rd_inhibit | output | 1 | High while a read must not be started |
| upd_load | output | 1 | One-cycle strobe committing the new word |

## Verification
Every status output is a register, so a strobe sampled at one clock edge shows up on `rdy_n` and `rd_inhibit` right after that same edge. The bench drives inputs just after a falling edge and reads outputs at the next falling edge, half a period after the edge that sampled them. The load strobe is due BLANK_CYC edges after the edge that sampled `upd_req`. The bench counts those edges, checks that the strobe is absent in every earlier cycle and present in exactly that cycle, and for a window cut by standby adds the frozen cycles. A full read raises `rdy_n` in the cycle after its last bit strobe. The sweep over every partial length confirms that the line does not move before that point.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BLANK = 2'd1,
    SEQ_LOAD  = 2'd2
  } seq_state_e;

  // true when the bit index points at the final bit of a word
  function automatic logic is_final_bit(input int unsigned idx, input int unsigned bits);
    return idx == bits - 1;
  endfunction

  // true when the blanking countdown has no cycles left
  function automatic logic blank_spent(input int unsigned left);
    return left == 0;
  endfunction

endpackage

// File: rtl/drdy_update_seq.sv
module drdy_update_seq
  import drdy_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic upd_req,
  input  logic upd_end,
  output logic busy,
  output logic load,
  output logic acc_req,
  output logic acc_end
);
  localparam int unsigned CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);

  seq_state_e     st_q;
  logic [CW-1:0]  left_q;
  logic           load_q;

  assign acc_req = run && upd_req && (st_q == SEQ_IDLE);
  assign acc_end = run && upd_end && (st_q == SEQ_LOAD);
  assign busy    = (st_q != SEQ_IDLE);
  assign load    = load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      left_q <= '0;
      load_q <= 1'b0;
    end else if (!run) begin
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (upd_req) begin
            st_q   <= SEQ_BLANK;
            left_q <= CW'(BLANK_CYC - 1);
          end
        end
        SEQ_BLANK: begin
          if (blank_spent(32'(left_q))) begin
            st_q   <= SEQ_LOAD;
            load_q <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        SEQ_LOAD: begin
          if (upd_end) st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // R3: the commit strobe lasts one cycle
  p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  // R3: the commit happens inside the inhibit window
  p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> busy);
  // R4: an accepted end releases the inhibit
  p_end_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> !busy);

endmodule

// File: rtl/drdy_word_track.sv
module drdy_word_track
  import drdy_pkg::*;
#(
  parameter int unsigned WORD_BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cs_n,
  input  logic sck_edge,
  input  logic inhibit,
  output logic word_done
);
  localparam int unsigned BW = (WORD_BITS < 2) ? 1 : $clog2(WORD_BITS);

  logic [BW-1:0] bit_q;

  assign word_done = run && !cs_n && sck_edge && !inhibit &&
                     is_final_bit(32'(bit_q), WORD_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
    end else if (run) begin
      if (cs_n) begin
        bit_q <= '0;
      end else if (sck_edge) begin
        if (inhibit || word_done) bit_q <= '0;
        else                      bit_q <= bit_q + 1'b1;
      end
    end
  end

  // R6: releasing chip select drops any partial word
  p_cs_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cs_n) |=> (bit_q == '0));
  // R8: a bit during the inhibit window clears the count
  p_inhibit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cs_n && sck_edge && inhibit) |=> (bit_q == '0));

endmodule

// File: rtl/drdy_ready_ctrl.sv
module drdy_ready_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cal_mode,
  input  logic cal_start,
  input  logic cal_done,
  input  logic upd_start,
  input  logic upd_fin,
  input  logic word_done,
  output logic rdy_n,
  output logic cal_busy
);
  logic rdy_q, rdy_d;
  logic cal_q, cal_d;

  always_comb begin
    rdy_d = rdy_q;
    cal_d = cal_q;
    if (run) begin
      if (cal_mode) begin
        if (cal_start) begin
          rdy_d = 1'b1;
          cal_d = 1'b1;
        end else if (cal_done && cal_q) begin
          rdy_d = 1'b0;
          cal_d = 1'b0;
        end
      end else begin
        cal_d = 1'b0;
        if (upd_start)      rdy_d = 1'b1;
        else if (upd_fin)   rdy_d = 1'b0;
        else if (word_done) rdy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      cal_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      cal_q <= cal_d;
    end
  end

  assign rdy_n    = rdy_q;
  assign cal_busy = cal_q;

  // R10: a running calibration keeps the line high
  p_cal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> rdy_n);
  // R12: standby freezes the ready line
  p_stby_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(rdy_n));

endmodule

// File: rtl/drdy_status_ctrl.sv
module drdy_status_ctrl #(
  parameter int unsigned BLANK_CYC = 4,
  parameter int unsigned WORD_BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_n,
  input  logic cal_mode,
  input  logic upd_req,
  input  logic upd_end,
  input  logic cal_start,
  input  logic cal_done,
  input  logic cs_n,
  input  logic sck_edge,
  output logic rdy_n,
  output logic rd_inhibit,
  output logic upd_load
);
  logic upd_busy;
  logic upd_accept;
  logic upd_finish;
  logic word_done;
  logic cal_busy;

  drdy_update_seq #(.BLANK_CYC(BLANK_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (stby_n),
    .upd_req (upd_req),
    .upd_end (upd_end),
    .busy    (upd_busy),
    .load    (upd_load),
    .acc_req (upd_accept),
    .acc_end (upd_finish)
  );

  drdy_word_track #(.WORD_BITS(WORD_BITS)) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (stby_n),
    .cs_n      (cs_n),
    .sck_edge  (sck_edge),
    .inhibit   (upd_busy),
    .word_done (word_done)
  );

  drdy_ready_ctrl u_rdy (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (stby_n),
    .cal_mode  (cal_mode),
    .cal_start (cal_start),
    .cal_done  (cal_done),
    .upd_start (upd_accept),
    .upd_fin   (upd_finish),
    .word_done (word_done),
    .rdy_n     (rdy_n),
    .cal_busy  (cal_busy)
  );

  assign rd_inhibit = upd_busy;

  // R2: an accepted request raises ready and inhibit together
  p_req_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_accept && !cal_mode) |=> (rdy_n && rd_inhibit));
  // R5: a finished read in conversion mode raises ready
  p_read_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cal_mode) |=> rdy_n);
  // R12: no commit strobe in standby
  p_stby_noload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> !upd_load);
  // R8: a completed word never coincides with the inhibit window
  p_done_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !rd_inhibit);

endmodule

// File: tb/sim_drdy_status_ctrl.sv
`timescale 1ns/1ps
module sim_drdy_status_ctrl;
  localparam int unsigned BL = 3;
  localparam int unsigned WB = 8;

  logic clk = 1'b0;
  logic rst_n, stby_n, cal_mode, upd_req, upd_end, cal_start, cal_done, cs_n, sck_edge;
  logic rdy_n, rd_inhibit, upd_load;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  drdy_status_ctrl #(.BLANK_CYC(BL), .WORD_BITS(WB)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cal_mode(cal_mode),
    .upd_req(upd_req), .upd_end(upd_end), .cal_start(cal_start),
    .cal_done(cal_done), .cs_n(cs_n), .sck_edge(sck_edge),
    .rdy_n(rdy_n), .rd_inhibit(rd_inhibit), .upd_load(upd_load)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      sck_edge = 1'b1; tick(); sck_edge = 1'b0;
    end
  endtask

  task automatic req_pulse();
    upd_req = 1'b1; tick(); upd_req = 1'b0;
  endtask

  task automatic end_pulse();
    upd_end = 1'b1; tick(); upd_end = 1'b0;
  endtask

  task automatic full_update();
    req_pulse();
    repeat (BL) tick();
    end_pulse();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; stby_n = 1'b1; cal_mode = 1'b0; upd_req = 1'b0; upd_end = 1'b0;
    cal_start = 1'b0; cal_done = 1'b0; cs_n = 1'b1; sck_edge = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 rdy_n after reset", rdy_n, 1'b1);
    chk("R1 rd_inhibit after reset", rd_inhibit, 1'b0);
    chk("R1 upd_load after reset", upd_load, 1'b0);
    cs_n = 1'b0; bits(WB); cs_n = 1'b1; tick();
    chk("R1 rdy_n before first update", rdy_n, 1'b1);

    // R2/R3/R4: request, blanking window, commit, end
    req_pulse();
    chk("R2 rdy_n after request", rdy_n, 1'b1);
    chk("R2 inhibit after request", rd_inhibit, 1'b1);
    for (int k = 1; k <= BL + 2; k++) begin
      chk("R3 load timing", upd_load, (k == BL + 1) ? 1'b1 : 1'b0);
      chk("R3 inhibit in window", rd_inhibit, 1'b1);
      if (k == 2) begin
        upd_req = 1'b1; tick(); upd_req = 1'b0;
      end else begin
        tick();
      end
    end
    end_pulse();
    chk("R4 rdy_n after end", rdy_n, 1'b0);
    chk("R4 inhibit after end", rd_inhibit, 1'b0);
    chk("R1 first completion lowers", rdy_n, 1'b0);
    repeat (BL + 2) begin
      chk("R2 repeated request ignored", upd_load, 1'b0);
      tick();
    end

    // R6: every partial length leaves ready low
    for (int n = 1; n < int'(WB); n++) begin
      cs_n = 1'b0; bits(n); cs_n = 1'b1; tick();
      chk("R6 partial read", rdy_n, 1'b0);
    end
    cs_n = 1'b0; bits(WB - 1);
    chk("R5 one bit short", rdy_n, 1'b0);
    bits(1);
    chk("R5 full read", rdy_n, 1'b1);
    cs_n = 1'b1; tick();

    // R2: unread word still raises ready for an update
    full_update();
    chk("R4 back low", rdy_n, 1'b0);
    req_pulse();
    chk("R2 unread word raises", rdy_n, 1'b1);
    repeat (BL) tick();
    end_pulse();
    chk("R4 low after unread update", rdy_n, 1'b0);

    // R7: chip select tied low
    cs_n = 1'b0;
    bits(WB);
    chk("R7 first framed word", rdy_n, 1'b1);
    full_update();
    bits(WB);
    chk("R7 second framed word", rdy_n, 1'b1);
    full_update();

    // R8: a bit during the inhibit window clears the partial count
    bits(3);
    req_pulse();
    bits(1);
    repeat (BL - 1) tick();
    end_pulse();
    bits(WB - 3);
    chk("R8 inhibited bit discarded count", rdy_n, 1'b0);
    bits(3);
    chk("R8 fresh word counted", rdy_n, 1'b1);

    // R4: stray end ignored
    end_pulse();
    chk("R4 stray end ignored", rdy_n, 1'b1);

    // R11: calibration strobes ignored in conversion mode
    full_update();
    cal_start = 1'b1; tick(); cal_start = 1'b0;
    chk("R11 cal_start ignored", rdy_n, 1'b0);
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    chk("R11 cal_done ignored", rdy_n, 1'b0);

    // R9: calibration mode
    cal_mode = 1'b1; tick();
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    chk("R9 cal_done without start", rdy_n, 1'b0);
    cal_start = 1'b1; tick(); cal_start = 1'b0;
    chk("R9 cal_start raises", rdy_n, 1'b1);
    full_update();
    chk("R9 update end ignored", rdy_n, 1'b1);
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    chk("R9 cal_done lowers", rdy_n, 1'b0);
    bits(WB);
    chk("R9 read ignored", rdy_n, 1'b0);
    req_pulse();
    chk("R9 request ignored", rdy_n, 1'b0);
    chk("R9 inhibit still tracks", rd_inhibit, 1'b1);
    repeat (BL) tick();
    end_pulse();

    // R10: calibration during an update
    req_pulse();
    cal_start = 1'b1; tick(); cal_start = 1'b0;
    repeat (BL - 1) tick();
    end_pulse();
    chk("R10 held past end", rdy_n, 1'b1);
    chk("R10 inhibit released", rd_inhibit, 1'b0);
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    chk("R10 cal_done lowers", rdy_n, 1'b0);
    cal_mode = 1'b0; tick();

    // R12: standby
    stby_n = 1'b0;
    req_pulse();
    bits(5);
    chk("R12 rdy held", rdy_n, 1'b0);
    chk("R12 no inhibit", rd_inhibit, 1'b0);
    chk("R12 no load", upd_load, 1'b0);
    stby_n = 1'b1;
    bits(3);
    chk("R12 bits not counted", rdy_n, 1'b0);
    bits(WB - 3);
    chk("R12 word after standby", rdy_n, 1'b1);
    full_update();
    req_pulse();
    stby_n = 1'b0;
    repeat (5) begin
      tick();
      chk("R12 frozen window load", upd_load, 1'b0);
      chk("R12 frozen window inhibit", rd_inhibit, 1'b1);
    end
    stby_n = 1'b1;
    for (int k = 1; k <= BL; k++) begin
      tick();
      chk("R12 resumed window", upd_load, (k == BL) ? 1'b1 : 1'b0);
    end
    end_pulse();
    chk("R12 update completes", rdy_n, 1'b0);

    summary();
    $finish;
  end
endmodule